// File: doc/BRIEF.md
# Pointer-Walked Nibble Data Store

This block is the data memory of a small 4-bit controller core: 256 words of 4 bits, addressed by a pointer split into a high half and a low half. The pointer sits inside the block. The core issues one decoded operation per clock, together with an immediate nibble and the current accumulator value. The block returns the word read at the pointer, the accumulator value after the operation and a zero flag.

Exchange operations swap the accumulator with the addressed word. They then move the pointer in the same cycle, so that a loop can walk through a table one nibble at a time. The zero flag is taken from the pointer half that was just changed, which lets the loop end without a separate compare. Single-bit set and clear of the addressed word, direct pointer loads, and a plain load and store complete the set. Every operation completes in one synchronous cycle.

Top module: `dp_nibble_ram`

## Requirements
- R1: While `rst` is high and after its release, `ptr_hi`, `ptr_lo`, `zf`, `acc_out` and `rd_data` read zero. Memory contents are not initialised.
- R2: The word address is `{ptr_hi, ptr_lo}`. Op code 1 (pointer-load-zero) clears `ptr_hi`, loads `ptr_lo` with `imm` and leaves memory unchanged.
- R3: Op code 2 (load-high) loads `ptr_hi` with `imm` and leaves `ptr_lo` unchanged.
- R4: Op code 3 adds one to `ptr_lo` and op code 4 subtracts one, both modulo 16 with no carry or borrow into `ptr_hi`. `zf` becomes 1 exactly when the new `ptr_lo` is 0.
- R5: Op code 5 (exchange-up) writes `acc_in` into the addressed word, presents the word's previous value on `acc_out`, then adds one to `ptr_lo` (modulo 16). `zf` reflects the new `ptr_lo`.
- R6: Op code 6 (exchange-down) performs the same swap, then subtracts one from `ptr_lo` (modulo 16). `zf` reflects the new `ptr_lo`.
- R7: Op code 7 (exchange-flip) performs the same swap, then XORs `ptr_hi` with `{1'b0, imm[2:0]}`. `imm[3]` is ignored, `ptr_lo` is unchanged, and `zf` becomes 1 exactly when the new `ptr_hi` is 0.
- R8: Op code 8 forces bit `imm[1:0]` of the addressed word to 1 and op code 9 forces it to 0. The other three bits, the pointer and `acc_out` are unchanged.
- R9: Op code 10 (load) copies the addressed word to `acc_out`. Op code 11 (store) writes `acc_in` into the addressed word.
- R10: After every clock edge out of reset, `rd_data` holds the word that was at the pointer just before that edge, read before that edge's write.
- R11: Op codes 0 and 12 to 15 change no pointer half, no memory word, and neither `zf` nor `acc_out`.
- R12: `zf` keeps its value on every operation other than op codes 3 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Decoded operation code |
| imm | input | 4 | Immediate operand (pointer value, bit select or flip mask) |
| acc_in | input | 4 | Accumulator value from the core |
| rd_data | output | 4 | Registered word read at the pre-operation pointer |
| acc_out | output | 4 | Accumulator value after the operation |
| zf | output | 1 | Zero flag from the last pointer update |
| ptr_hi | output | 4 | High half of the data pointer |
| ptr_lo | output | 4 | Low half of the data pointer |

## Verification
The properties assume that `op`, `imm` and `acc_in` are known and stable around each rising edge. The exchange property also assumes that the word being swapped has been written since power-up, because it compares `acc_out` against `rd_data`. The bench changes inputs only on falling edges. Before any random traffic it stores a value into all 256 words with a directed pass. After that, random op codes (including the unused ones) only ever read initialised memory.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LDZ   = 4'd1,
    OP_LHI   = 4'd2,
    OP_INCL  = 4'd3,
    OP_DECL  = 4'd4,
    OP_XINC  = 4'd5,
    OP_XDEC  = 4'd6,
    OP_XMOD  = 4'd7,
    OP_SETB  = 4'd8,
    OP_CLRB  = 4'd9,
    OP_LOAD  = 4'd10,
    OP_STORE = 4'd11
  } op_e;

  typedef enum logic [2:0] {
    PTR_HOLD,
    PTR_LDZ,
    PTR_LHI,
    PTR_INC,
    PTR_DEC,
    PTR_XOR
  } ptr_act_e;

  typedef enum logic [1:0] {
    WR_NONE,
    WR_ACC,
    WR_SET,
    WR_CLR
  } wr_act_e;

  typedef struct packed {
    ptr_act_e ptr;
    wr_act_e  wr;
    logic     acc_ld;
  } ctl_t;

endpackage

// File: rtl/dpr_decode.sv
module dpr_decode
  import dpr_pkg::*;
(
  input  logic [3:0] op,
  output ctl_t       ctl
);

  always_comb begin
    ctl.ptr    = PTR_HOLD;
    ctl.wr     = WR_NONE;
    ctl.acc_ld = 1'b0;
    case (op)
      OP_LDZ:  ctl.ptr = PTR_LDZ;
      OP_LHI:  ctl.ptr = PTR_LHI;
      OP_INCL: ctl.ptr = PTR_INC;
      OP_DECL: ctl.ptr = PTR_DEC;
      OP_XINC: begin
        ctl.ptr    = PTR_INC;
        ctl.wr     = WR_ACC;
        ctl.acc_ld = 1'b1;
      end
      OP_XDEC: begin
        ctl.ptr    = PTR_DEC;
        ctl.wr     = WR_ACC;
        ctl.acc_ld = 1'b1;
      end
      OP_XMOD: begin
        ctl.ptr    = PTR_XOR;
        ctl.wr     = WR_ACC;
        ctl.acc_ld = 1'b1;
      end
      OP_SETB:  ctl.wr     = WR_SET;
      OP_CLRB:  ctl.wr     = WR_CLR;
      OP_LOAD:  ctl.acc_ld = 1'b1;
      OP_STORE: ctl.wr     = WR_ACC;
      default: ;
    endcase
  end

endmodule

// File: rtl/dpr_pointer.sv
module dpr_pointer
  import dpr_pkg::*;
#(
  parameter int HI_W  = 4,
  parameter int LO_W  = 4,
  parameter int IMM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ptr_act_e         act,
  input  logic [IMM_W-1:0] imm,
  output logic [HI_W-1:0]  hi,
  output logic [LO_W-1:0]  lo,
  output logic             zf
);

  localparam int MSK_W = HI_W - 1;

  logic [HI_W-1:0] flip_mask;
  logic [LO_W-1:0] lo_up;
  logic [LO_W-1:0] lo_dn;
  logic [HI_W-1:0] hi_flip;

  assign flip_mask = {1'b0, imm[MSK_W-1:0]};
  assign lo_up     = lo + LO_W'(1);
  assign lo_dn     = lo - LO_W'(1);
  assign hi_flip   = hi ^ flip_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= '0;
      lo <= '0;
      zf <= 1'b0;
    end else begin
      case (act)
        PTR_LDZ: begin
          hi <= '0;
          lo <= LO_W'(imm);
        end
        PTR_LHI: hi <= HI_W'(imm);
        PTR_INC: begin
          lo <= lo_up;
          zf <= (lo_up == '0);
        end
        PTR_DEC: begin
          lo <= lo_dn;
          zf <= (lo_dn == '0);
        end
        PTR_XOR: begin
          hi <= hi_flip;
          zf <= (hi_flip == '0);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dpr_store.sv
module dpr_store
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  wr_act_e           wr,
  input  logic [DW-1:0]     wdata_acc,
  input  logic [SEL_W-1:0]  sel,
  output logic [DW-1:0]     cur
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] bit_mod;
  logic [DW-1:0] wdata;

  assign cur = mem[addr];

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign bit_mod[b] = (sel == SEL_W'(b)) ? (wr == WR_SET) : cur[b];
  end

  assign wdata = (wr == WR_ACC) ? wdata_acc : bit_mod;

  always_ff @(posedge clk) begin
    if (wr != WR_NONE) begin
      mem[addr] <= wdata;
    end
  end

endmodule

// File: rtl/dpr_result.sv
module dpr_result #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_ld,
  input  logic [DW-1:0] cur,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] acc_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      acc_out <= '0;
    end else begin
      rd_data <= cur;
      if (acc_ld) begin
        acc_out <= cur;
      end
    end
  end

endmodule

// File: rtl/dp_nibble_ram.sv
module dp_nibble_ram
  import dpr_pkg::*;
#(
  parameter int HI_W  = 4,
  parameter int LO_W  = 4,
  parameter int DW    = 4,
  parameter int IMM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op,
  input  logic [IMM_W-1:0] imm,
  input  logic [DW-1:0]    acc_in,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    acc_out,
  output logic             zf,
  output logic [HI_W-1:0]  ptr_hi,
  output logic [LO_W-1:0]  ptr_lo
);

  localparam int ADDR_W = HI_W + LO_W;
  localparam int SEL_W  = (DW > 1) ? $clog2(DW) : 1;

  ctl_t          ctl;
  logic [DW-1:0] cur;

  dpr_decode u_dec (
    .op  (op),
    .ctl (ctl)
  );

  dpr_pointer #(
    .HI_W  (HI_W),
    .LO_W  (LO_W),
    .IMM_W (IMM_W)
  ) u_ptr (
    .clk (clk),
    .rst (rst),
    .act (ctl.ptr),
    .imm (imm),
    .hi  (ptr_hi),
    .lo  (ptr_lo),
    .zf  (zf)
  );

  dpr_store #(
    .ADDR_W (ADDR_W),
    .DW     (DW),
    .SEL_W  (SEL_W)
  ) u_mem (
    .clk       (clk),
    .addr      ({ptr_hi, ptr_lo}),
    .wr        (ctl.wr),
    .wdata_acc (acc_in),
    .sel       (imm[SEL_W-1:0]),
    .cur       (cur)
  );

  dpr_result #(
    .DW (DW)
  ) u_res (
    .clk     (clk),
    .rst     (rst),
    .acc_ld  (ctl.acc_ld),
    .cur     (cur),
    .rd_data (rd_data),
    .acc_out (acc_out)
  );

endmodule

// File: rtl/dp_nibble_ram_chk.sv
module dp_nibble_ram_chk #(
  parameter int HI_W  = 4,
  parameter int LO_W  = 4,
  parameter int DW    = 4,
  parameter int IMM_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op,
  input logic [IMM_W-1:0] imm,
  input logic [DW-1:0]    rd_data,
  input logic [DW-1:0]    acc_out,
  input logic             zf,
  input logic [HI_W-1:0]  ptr_hi,
  input logic [LO_W-1:0]  ptr_lo
);

  localparam logic [HI_W-1:0] XMASK = {1'b0, {(HI_W-1){1'b1}}};

  assert_ldz_R2: assert property (@(posedge clk) disable iff (rst)
    op == 4'd1 |=> (ptr_hi == '0) && (ptr_lo == $past(LO_W'(imm))));

  assert_inc_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    op == 4'd3 |=> (ptr_lo == LO_W'($past(ptr_lo) + 1'b1)) && $stable(ptr_hi)
                   && (zf == (ptr_lo == '0)));

  assert_dec_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    op == 4'd4 |=> (ptr_lo == LO_W'($past(ptr_lo) - 1'b1)) && $stable(ptr_hi)
                   && (zf == (ptr_lo == '0)));

  assert_xinc_swap_R5: assert property (@(posedge clk) disable iff (rst)
    op == 4'd5 |=> (acc_out == rd_data) && (ptr_lo == LO_W'($past(ptr_lo) + 1'b1)));

  assert_xdec_swap_R6: assert property (@(posedge clk) disable iff (rst)
    op == 4'd6 |=> (acc_out == rd_data) && (ptr_lo == LO_W'($past(ptr_lo) - 1'b1)));

  assert_xmod_flip_R7: assert property (@(posedge clk) disable iff (rst)
    op == 4'd7 |=> (ptr_hi == ($past(ptr_hi) ^ ($past(HI_W'(imm)) & XMASK)))
                   && $stable(ptr_lo) && (zf == (ptr_hi == '0)));

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd0 || op >= 4'd12) |=> $stable(ptr_hi) && $stable(ptr_lo)
                                    && $stable(zf) && $stable(acc_out));

  assert_zf_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd1 || op == 4'd2 || (op >= 4'd8 && op <= 4'd11)) |=> $stable(zf));

endmodule

bind dp_nibble_ram dp_nibble_ram_chk #(
  .HI_W  (HI_W),
  .LO_W  (LO_W),
  .DW    (DW),
  .IMM_W (IMM_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op      (op),
  .imm     (imm),
  .rd_data (rd_data),
  .acc_out (acc_out),
  .zf      (zf),
  .ptr_hi  (ptr_hi),
  .ptr_lo  (ptr_lo)
);

// File: tb/dp_nibble_ram_tb.sv
`timescale 1ns/1ps
module dp_nibble_ram_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op = 4'd0;
  logic [3:0] imm = 4'd0;
  logic [3:0] acc_in = 4'd0;
  logic [3:0] rd_data, acc_out, ptr_hi, ptr_lo;
  logic       zf;

  always #4 clk = ~clk;

  dp_nibble_ram u_dut (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .imm     (imm),
    .acc_in  (acc_in),
    .rd_data (rd_data),
    .acc_out (acc_out),
    .zf      (zf),
    .ptr_hi  (ptr_hi),
    .ptr_lo  (ptr_lo)
  );

  int checks = 0;
  int fails  = 0;

  logic [3:0] m_mem [256];
  logic [3:0] m_hi = 4'd0, m_lo = 4'd0, m_acc = 4'd0, m_rd = 4'd0;
  logic       m_zf = 1'b0;

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd1:          return "R2";
      4'd2:          return "R3";
      4'd3, 4'd4:    return "R4";
      4'd5:          return "R5";
      4'd6:          return "R6";
      4'd7:          return "R7";
      4'd8, 4'd9:    return "R8";
      4'd10, 4'd11:  return "R9";
      default:       return "R11";
    endcase
  endfunction

  function automatic logic [3:0] force_bit(input logic [3:0] w, input logic [1:0] s,
                                           input logic v);
    logic [3:0] r = w;
    r[s] = v;
    return r;
  endfunction

  task automatic check(input string req);
    logic [16:0] got, exp;
    got = {ptr_hi, ptr_lo, zf, acc_out, rd_data};
    exp = {m_hi, m_lo, m_zf, m_acc, m_rd};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: hi/lo/zf/acc/rd actual %h/%h/%b/%h/%h expected %h/%h/%b/%h/%h",
               req, ptr_hi, ptr_lo, zf, acc_out, rd_data, m_hi, m_lo, m_zf, m_acc, m_rd);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, update model, compare.
  task automatic run_op(input logic [3:0] o, input logic [3:0] i, input logic [3:0] a,
                        input string req);
    logic [7:0] adr;
    logic [3:0] cur;
    op = o; imm = i; acc_in = a;
    @(posedge clk);
    @(negedge clk);
    adr  = {m_hi, m_lo};
    cur  = m_mem[adr];
    m_rd = cur;                                  // R10
    case (o)
      4'd1: begin m_hi = 4'd0; m_lo = i; end
      4'd2: m_hi = i;
      4'd3: begin m_lo = m_lo + 4'd1; m_zf = (m_lo == 4'd0); end
      4'd4: begin m_lo = m_lo - 4'd1; m_zf = (m_lo == 4'd0); end
      4'd5: begin m_mem[adr] = a; m_acc = cur; m_lo = m_lo + 4'd1; m_zf = (m_lo == 4'd0); end
      4'd6: begin m_mem[adr] = a; m_acc = cur; m_lo = m_lo - 4'd1; m_zf = (m_lo == 4'd0); end
      4'd7: begin m_mem[adr] = a; m_acc = cur; m_hi = m_hi ^ {1'b0, i[2:0]}; m_zf = (m_hi == 4'd0); end
      4'd8: m_mem[adr] = force_bit(cur, i[1:0], 1'b1);
      4'd9: m_mem[adr] = force_bit(cur, i[1:0], 1'b0);
      4'd10: m_acc = cur;
      4'd11: m_mem[adr] = a;
      default: ;
    endcase
    check(req);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 256; k++) m_mem[k] = 4'bx;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1");
    rst = 1'b0;
    run_op(4'd0, 4'd0, 4'd0, "R1");

    // Fill every word through store so later reads are defined (R9)
    for (int h = 0; h < 16; h++) begin
      run_op(4'd2, 4'(h), 4'd0, "R3");
      for (int l = 0; l < 16; l++) begin
        run_op(4'd11, 4'd0, 4'($urandom), "R9");
        run_op(4'd3, 4'd0, 4'd0, "R4");
      end
    end

    // R2 / R4: low half wraps without carry into the high half
    run_op(4'd1, 4'd15, 4'd0, "R2");
    run_op(4'd2, 4'd15, 4'd0, "R3");
    run_op(4'd3, 4'd0, 4'd0, "R4");
    run_op(4'd4, 4'd0, 4'd0, "R4");
    run_op(4'd4, 4'd9, 4'd0, "R4");
    // R7: top immediate bit ignored; flip back to zero sets zf
    run_op(4'd7, 4'd15, 4'd3, "R7");
    run_op(4'd7, 4'd8, 4'd5, "R7");
    run_op(4'd2, 4'd5, 4'd0, "R3");
    run_op(4'd7, 4'd5, 4'd6, "R7");
    // R5 / R6 at the wrap points
    run_op(4'd1, 4'd15, 4'd0, "R2");
    run_op(4'd5, 4'd0, 4'd10, "R5");
    run_op(4'd6, 4'd0, 4'd12, "R6");
    run_op(4'd6, 4'd0, 4'd1, "R6");
    // R8: each bit set then cleared, read back via load (R9) and rd_data (R10)
    for (int b = 0; b < 4; b++) begin
      run_op(4'd8, 4'(b), 4'd0, "R8");
      run_op(4'd10, 4'd0, 4'd0, "R9");
      run_op(4'd9, 4'(b), 4'd0, "R8");
      run_op(4'd0, 4'd0, 4'd0, "R10");
    end
    // R11 / R12: unused codes and zf hold
    run_op(4'd3, 4'd0, 4'd0, "R4");
    for (int c = 12; c < 16; c++) run_op(4'(c), 4'($urandom), 4'($urandom), "R11");
    run_op(4'd0, 4'd0, 4'd0, "R11");
    run_op(4'd2, 4'd0, 4'd0, "R12");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] o;
      o = 4'($urandom);
      run_op(o, 4'($urandom), 4'($urandom), req_of(o));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule